// File: doc/BRIEF.md
# FPGA Configuration Scrub Controller

This block sequences the upkeep of a target FPGA's configuration memory from images held in non-volatile storage. A 3-bit mode input selects the operation: scrub on request, repeated scrubbing paced by a programmable gap, readback with verification, clear-then-configure, reading a stored image from flash, or reading the configuration memory back. The block does not drive the configuration port or the flash. It starts those engines with one-cycle start pulses and an operation code, then waits for their done or error reply.

Two safety mechanisms sit alongside the mode logic. A watchdog counts cycles since the target last produced a life pulse. If the count runs out, the block forces a hard reset: a clear of configuration memory followed by a full configuration. A verification error reported by the readback checker schedules a scrub at once. Errors reported by the engines set sticky status flags, which a clear strobe resets. The flash bank in use is latched with every start so that it cannot change while an operation is running.

Top module: `cfg_scrub_ctrl`

## Requirements
- R1: After reset, cfgStart, flashStart, busy and all three error flags are 0.
- R2: In mode 0, a goStrobe pulse while idle causes one cfgStart pulse, one cycle long, with cfgOp = 0 (scrub). busy then stays 1 until the engine returns done or error.
- R3: goStrobe has no effect while busy is 1, or when the mode is 6 or 7. In those cases no start pulse appears and busy stays as it was.
- R4: In mode 3, goStrobe issues cfgOp = 1 (clear). When that operation returns done, cfgOp = 2 (configure) is issued next. If the clear returns an error, no configure is issued.
- R5: goStrobe issues cfgOp = 3 (readback and verify) in mode 2 and cfgOp = 4 (read configuration) in mode 5. In mode 4 it issues a one-cycle flashStart, and cfgStart stays low.
- R6: A verifyErr pulse, whether it arrives while idle or during an operation, leads to a scrub start (cfgOp = 0) once the controller is idle.
- R7: In mode 1, scrubs repeat with no goStrobe. Each scrub start follows the done of the previous scrub by scrubRate+1 cycles.
- R8: Each lifePulse reloads the watchdog. If wdMax cycles pass without a pulse, the block issues clear (cfgOp = 1) and then configure (cfgOp = 2). A wdMax of 0 disables the watchdog.
- R9: The watchdog does not advance while a clear or configure operation is in progress. It counts again from zero once that operation ends.
- R10: cfgErr on a scrub sets scrubErrFlag. cfgErr on any other configuration operation sets cfgErrFlag. flashErr sets flashErrFlag. The flags stay set until statusClr.
- R11: imageBank takes the value of flashBank on each start pulse and holds it while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 3 | Operation mode |
| goStrobe | input | 1 | Start request for the selected mode |
| statusClr | input | 1 | Clears the error flags |
| wdMax | input | WD_W | Watchdog limit in cycles, 0 disables it |
| scrubRate | input | RATE_W | Idle gap between scrubs in mode 1 |
| flashBank | input | BANK_W | Selected stored image |
| lifePulse | input | 1 | Heartbeat from the target |
| verifyErr | input | 1 | Mismatch pulse from the readback checker |
| cfgStart | output | 1 | Start pulse to the configuration-port engine |
| cfgOp | output | 3 | Operation code for the configuration-port engine |
| cfgDone | input | 1 | Configuration operation finished |
| cfgErr | input | 1 | Configuration operation failed |
| flashStart | output | 1 | Start pulse to the flash reader |
| flashDone | input | 1 | Flash read finished |
| flashErr | input | 1 | Flash read failed |
| imageBank | output | BANK_W | Bank latched at the last start |
| busy | output | 1 | An operation is in progress |
| scrubErrFlag | output | 1 | Sticky scrub error flag |
| cfgErrFlag | output | 1 | Sticky configuration error flag |
| flashErrFlag | output | 1 | Sticky flash error flag |

## Verification
The bench targets these corner cases:
- **Clear-to-configure chaining, with and without a failed clear.** A controller that always chains would issue a configure the queue does not expect. One that never chains would leave a configure entry unused.
- **Verification error during a readback.** A design that only samples verifyErr while idle would lose the scrub.
- **Scrub spacing in continuous mode.** This is measured as an exact cycle gap, so an off-by-one in the gap counter shows up.
- **Watchdog behaviour across its full range.** The bench checks that regular life pulses keep it quiet, that a limit of zero disables it, and that a clear or configure operation lasting longer than the limit does not set off a second hard reset. A counter that keeps running during reconfiguration would start a new clear as soon as the configure finished.

// File: rtl/cfg_scrub_pkg.sv
package cfg_scrub_pkg;

  typedef enum logic [2:0] {
    OP_SCRUB   = 3'd0,
    OP_CLEAR   = 3'd1,
    OP_CONFIG  = 3'd2,
    OP_VERIFY  = 3'd3,
    OP_READCFG = 3'd4
  } cfgOp_e;

  localparam logic [2:0] MODE_DEMAND  = 3'd0;
  localparam logic [2:0] MODE_CONT    = 3'd1;
  localparam logic [2:0] MODE_VERIFY  = 3'd2;
  localparam logic [2:0] MODE_RELOAD  = 3'd3;
  localparam logic [2:0] MODE_FLASHRD = 3'd4;
  localparam logic [2:0] MODE_CFGRD   = 3'd5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CFG   = 2'd1,
    ST_FLASH = 2'd2
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   cfgGo;
    cfgOp_e op;
    logic   flashGo;
    logic   setScrubErr;
    logic   setCfgErr;
    logic   setFlashErr;
    logic   clrVerify;
    logic   clrWd;
    logic   wdHold;
    logic   rateRun;
  } ctlStrobe_t;

endpackage

// File: rtl/cfg_scrub_fsm.sv
module cfg_scrub_fsm
  import cfg_scrub_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] modeSel,
  input  logic       goStrobe,
  input  logic       cfgDone,
  input  logic       cfgErr,
  input  logic       flashDone,
  input  logic       flashErr,
  input  logic       wdPend,
  input  logic       verifyPend,
  input  logic       rateHit,
  output ctlStrobe_t strb,
  output logic       busy
);

  ctlState_e state, stateNxt;
  cfgOp_e    curOp, curOpNxt;
  logic      issue;
  cfgOp_e    issueOp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      curOp <= OP_SCRUB;
    end else begin
      state <= stateNxt;
      curOp <= curOpNxt;
    end
  end

  always_comb begin
    strb     = '0;
    stateNxt = state;
    curOpNxt = curOp;
    issue    = 1'b0;
    issueOp  = OP_SCRUB;

    strb.wdHold  = (state == ST_CFG) && ((curOp == OP_CLEAR) || (curOp == OP_CONFIG));
    strb.rateRun = (state == ST_IDLE) && (modeSel == MODE_CONT);

    unique case (state)
      ST_IDLE: begin
        if (wdPend) begin
          issue      = 1'b1;
          issueOp    = OP_CLEAR;
          strb.clrWd = 1'b1;
        end else if (verifyPend) begin
          issue          = 1'b1;
          issueOp        = OP_SCRUB;
          strb.clrVerify = 1'b1;
        end else begin
          case (modeSel)
            MODE_DEMAND:  if (goStrobe) begin issue = 1'b1; issueOp = OP_SCRUB;   end
            MODE_CONT:    if (rateHit)  begin issue = 1'b1; issueOp = OP_SCRUB;   end
            MODE_VERIFY:  if (goStrobe) begin issue = 1'b1; issueOp = OP_VERIFY;  end
            MODE_RELOAD:  if (goStrobe) begin issue = 1'b1; issueOp = OP_CLEAR;   end
            MODE_CFGRD:   if (goStrobe) begin issue = 1'b1; issueOp = OP_READCFG; end
            MODE_FLASHRD: if (goStrobe) begin
              strb.flashGo = 1'b1;
              stateNxt     = ST_FLASH;
            end
            default: ;
          endcase
        end
      end
      ST_CFG: begin
        if (cfgErr) begin
          if (curOp == OP_SCRUB) strb.setScrubErr = 1'b1;
          else                   strb.setCfgErr   = 1'b1;
          stateNxt = ST_IDLE;
        end else if (cfgDone) begin
          if (curOp == OP_CLEAR) begin
            issue   = 1'b1;
            issueOp = OP_CONFIG;
          end else begin
            stateNxt = ST_IDLE;
          end
        end
      end
      ST_FLASH: begin
        if (flashErr) begin
          strb.setFlashErr = 1'b1;
          stateNxt         = ST_IDLE;
        end else if (flashDone) begin
          stateNxt = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase

    if (issue) begin
      strb.cfgGo = 1'b1;
      strb.op    = issueOp;
      curOpNxt   = issueOp;
      stateNxt   = ST_CFG;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/cfg_scrub_dp.sv
module cfg_scrub_dp
  import cfg_scrub_pkg::*;
#(
  parameter int WD_W   = 24,
  parameter int RATE_W = 24,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic              statusClr,
  input  logic [WD_W-1:0]   wdMax,
  input  logic [RATE_W-1:0] scrubRate,
  input  logic [BANK_W-1:0] flashBank,
  input  logic              lifePulse,
  input  logic              verifyErr,
  output logic              cfgStart,
  output logic [2:0]        cfgOp,
  output logic              flashStart,
  output logic [BANK_W-1:0] imageBank,
  output logic              scrubErrFlag,
  output logic              cfgErrFlag,
  output logic              flashErrFlag,
  output logic              wdPend,
  output logic              verifyPend,
  output logic              rateHit
);

  localparam logic [RATE_W-1:0] RATE_SAT = {RATE_W{1'b1}};

  logic [WD_W-1:0]   wdCnt;
  logic [WD_W-1:0]   wdLimit;
  logic [RATE_W-1:0] rateCnt;

  assign wdLimit = wdMax - {{(WD_W-1){1'b0}}, 1'b1};

  // watchdog: reload on life pulse, frozen at zero during clear/configure
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdCnt  <= '0;
      wdPend <= 1'b0;
    end else begin
      if (strb.clrWd) wdPend <= 1'b0;
      if (strb.wdHold || lifePulse || (wdMax == '0)) begin
        wdCnt <= '0;
      end else if (wdCnt >= wdLimit) begin
        wdCnt  <= '0;
        wdPend <= 1'b1;
      end else begin
        wdCnt <= wdCnt + 1'b1;
      end
    end
  end

  // idle gap counter for continuous scrubbing
  always_ff @(posedge clk) begin
    if (!rstN || !strb.rateRun) rateCnt <= '0;
    else if (rateCnt != RATE_SAT) rateCnt <= rateCnt + 1'b1;
  end
  assign rateHit = (rateCnt >= scrubRate);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgStart   <= 1'b0;
      flashStart <= 1'b0;
      cfgOp      <= '0;
      imageBank  <= '0;
      verifyPend <= 1'b0;
    end else begin
      cfgStart   <= strb.cfgGo;
      flashStart <= strb.flashGo;
      if (strb.cfgGo) cfgOp <= strb.op;
      if (strb.cfgGo || strb.flashGo) imageBank <= flashBank;
      verifyPend <= (verifyPend & ~strb.clrVerify) | verifyErr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scrubErrFlag <= 1'b0;
      cfgErrFlag   <= 1'b0;
      flashErrFlag <= 1'b0;
    end else begin
      scrubErrFlag <= (scrubErrFlag & ~statusClr) | strb.setScrubErr;
      cfgErrFlag   <= (cfgErrFlag   & ~statusClr) | strb.setCfgErr;
      flashErrFlag <= (flashErrFlag & ~statusClr) | strb.setFlashErr;
    end
  end

endmodule

// File: rtl/cfg_scrub_ctrl.sv
module cfg_scrub_ctrl
  import cfg_scrub_pkg::*;
#(
  parameter int WD_W   = 24,
  parameter int RATE_W = 24,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        modeSel,
  input  logic              goStrobe,
  input  logic              statusClr,
  input  logic [WD_W-1:0]   wdMax,
  input  logic [RATE_W-1:0] scrubRate,
  input  logic [BANK_W-1:0] flashBank,
  input  logic              lifePulse,
  input  logic              verifyErr,
  output logic              cfgStart,
  output logic [2:0]        cfgOp,
  input  logic              cfgDone,
  input  logic              cfgErr,
  output logic              flashStart,
  input  logic              flashDone,
  input  logic              flashErr,
  output logic [BANK_W-1:0] imageBank,
  output logic              busy,
  output logic              scrubErrFlag,
  output logic              cfgErrFlag,
  output logic              flashErrFlag
);

  ctlStrobe_t strb;
  logic       wdPend;
  logic       verifyPend;
  logic       rateHit;

  cfg_scrub_fsm uFsm (
    .clk        (clk),
    .rstN       (rstN),
    .modeSel    (modeSel),
    .goStrobe   (goStrobe),
    .cfgDone    (cfgDone),
    .cfgErr     (cfgErr),
    .flashDone  (flashDone),
    .flashErr   (flashErr),
    .wdPend     (wdPend),
    .verifyPend (verifyPend),
    .rateHit    (rateHit),
    .strb       (strb),
    .busy       (busy)
  );

  cfg_scrub_dp #(
    .WD_W   (WD_W),
    .RATE_W (RATE_W),
    .BANK_W (BANK_W)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .statusClr    (statusClr),
    .wdMax        (wdMax),
    .scrubRate    (scrubRate),
    .flashBank    (flashBank),
    .lifePulse    (lifePulse),
    .verifyErr    (verifyErr),
    .cfgStart     (cfgStart),
    .cfgOp        (cfgOp),
    .flashStart   (flashStart),
    .imageBank    (imageBank),
    .scrubErrFlag (scrubErrFlag),
    .cfgErrFlag   (cfgErrFlag),
    .flashErrFlag (flashErrFlag),
    .wdPend       (wdPend),
    .verifyPend   (verifyPend),
    .rateHit      (rateHit)
  );

endmodule

// File: rtl/cfg_scrub_chk.sv
module cfg_scrub_chk #(
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgStart,
  input logic              flashStart,
  input logic              cfgDone,
  input logic              cfgErr,
  input logic              flashDone,
  input logic              flashErr,
  input logic              busy,
  input logic [BANK_W-1:0] imageBank,
  input logic              scrubErrFlag,
  input logic              flashErrFlag
);

  // R2
  start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgStart |=> !cfgStart);

  // R2
  start_marks_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgStart || flashStart) |-> busy);

  // R5
  single_engine_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgStart && flashStart));

  // R2
  busy_ends_on_reply_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(cfgDone || cfgErr || flashDone || flashErr));

  // R10
  scrub_flag_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(scrubErrFlag) |-> $past(cfgErr));

  // R10
  flash_flag_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashErrFlag) |-> $past(flashErr));

  // R11
  bank_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !cfgStart && !flashStart) |-> $stable(imageBank));

endmodule

bind cfg_scrub_ctrl cfg_scrub_chk #(.BANK_W(BANK_W)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .cfgStart     (cfgStart),
  .flashStart   (flashStart),
  .cfgDone      (cfgDone),
  .cfgErr       (cfgErr),
  .flashDone    (flashDone),
  .flashErr     (flashErr),
  .busy         (busy),
  .imageBank    (imageBank),
  .scrubErrFlag (scrubErrFlag),
  .flashErrFlag (flashErrFlag)
);

// File: tb/sim_cfg_scrub_ctrl.sv
module sim_cfg_scrub_ctrl;

  localparam int WD_W   = 24;
  localparam int RATE_W = 24;
  localparam int BANK_W = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [2:0]        modeSel = 3'd6;
  logic              goStrobe = 1'b0;
  logic              statusClr = 1'b0;
  logic [WD_W-1:0]   wdMax = '0;
  logic [RATE_W-1:0] scrubRate = '0;
  logic [BANK_W-1:0] flashBank = '0;
  logic              lifePulse = 1'b0;
  logic              verifyErr = 1'b0;
  logic              cfgStart;
  logic [2:0]        cfgOp;
  logic              cfgDone = 1'b0;
  logic              cfgErr = 1'b0;
  logic              flashStart;
  logic              flashDone = 1'b0;
  logic              flashErr = 1'b0;
  logic [BANK_W-1:0] imageBank;
  logic              busy;
  logic              scrubErrFlag, cfgErrFlag, flashErrFlag;

  always #5 clk = ~clk;

  cfg_scrub_ctrl #(.WD_W(WD_W), .RATE_W(RATE_W), .BANK_W(BANK_W)) u0 (.*);

  int  checks = 0;
  int  errors = 0;
  int  cyc = 0;
  int  startCnt = 0;
  int  lastStart = 0;
  bit  petOn = 1'b1;
  bit  injCfgErr = 1'b0;
  bit  injFlashErr = 1'b0;
  int  cfgLat = 3;
  int  cfgCnt = 0;
  int  flashCnt = 0;
  logic [5:0] expQ[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // expected item: {flash, op[2:0], bank}
  task automatic expectOp(input bit isFlash, input logic [2:0] op, input logic [BANK_W-1:0] bank);
    expQ.push_back({isFlash, op, bank});
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && (cfgStart || flashStart)) begin
      logic [5:0] got;
      got = {flashStart, flashStart ? 3'd0 : cfgOp, imageBank};
      startCnt++;
      lastStart = cyc;
      if (expQ.size() == 0) check(1'b0, "R3 unexpected start", 32'(got), 32'h0);
      else begin
        logic [5:0] e;
        e = expQ.pop_front();
        check(got == e, "R2/R4/R5/R6/R11 start item", 32'(got), 32'(e));
      end
    end
  end

  // engine models: reply cfgLat+1 cycles after the start is seen
  always @(negedge clk) begin
    cfgDone <= 1'b0; cfgErr <= 1'b0;
    if (cfgStart) cfgCnt <= cfgLat;
    else if (cfgCnt != 0) begin
      cfgCnt <= cfgCnt - 1;
      if (cfgCnt == 1) begin
        if (injCfgErr) cfgErr <= 1'b1; else cfgDone <= 1'b1;
      end
    end
    flashDone <= 1'b0; flashErr <= 1'b0;
    if (flashStart) flashCnt <= 3;
    else if (flashCnt != 0) begin
      flashCnt <= flashCnt - 1;
      if (flashCnt == 1) begin
        if (injFlashErr) flashErr <= 1'b1; else flashDone <= 1'b1;
      end
    end
  end

  always @(negedge clk) lifePulse <= petOn && (cyc % 10 == 0);

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go();
    @(negedge clk); goStrobe = 1'b1;
    @(negedge clk); goStrobe = 1'b0;
  endtask

  task automatic pulseVerify();
    @(negedge clk); verifyErr = 1'b1;
    @(negedge clk); verifyErr = 1'b0;
  endtask

  task automatic waitIdle();
    int quiet = 0;
    int guard = 0;
    while (quiet < 4 && guard < 3000) begin
      @(negedge clk);
      guard++;
      if (busy) quiet = 0; else quiet++;
    end
    check(guard < 3000, "R2 return to idle", 32'(guard), 32'd3000);
  endtask

  task automatic waitStart(output int t);
    int s = startCnt;
    int guard = 0;
    while (startCnt == s && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    check(startCnt != s, "R7/R8 expected start", 32'(startCnt), 32'(s + 1));
    t = lastStart;
  endtask

  task automatic drained(input string req);
    check(expQ.size() == 0, req, 32'(expQ.size()), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog timeout", 32'(cyc), 32'd0);
    finishRun();
  end

  initial begin
    int t1, t2, t3, tStop, s;
    waitCycles(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({cfgStart, flashStart, busy} == 3'b000, "R1 starts/busy", {cfgStart, flashStart, busy}, 0);
    check({scrubErrFlag, cfgErrFlag, flashErrFlag} == 3'b000, "R1 flags",
          {scrubErrFlag, cfgErrFlag, flashErrFlag}, 0);

    // R2 demand scrub
    modeSel = 3'd0; flashBank = 2'd2;
    expectOp(0, 3'd0, 2'd2);
    go();
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    waitIdle(); drained("R2 scrub issued");

    // R3 go while busy ignored
    expectOp(0, 3'd0, 2'd2);
    go(); go();
    waitIdle(); drained("R3 single start");
    // R3 modes 6 and 7 idle
    for (int m = 6; m < 8; m++) begin
      modeSel = 3'(m);
      s = startCnt;
      go(); waitCycles(10);
      check(startCnt == s && !busy, "R3 idle mode", 32'(startCnt), 32'(s));
    end

    // R4 clear then configure
    modeSel = 3'd3; flashBank = 2'd1;
    expectOp(0, 3'd1, 2'd1); expectOp(0, 3'd2, 2'd1);
    go(); waitIdle(); drained("R4 clear+config");

    // R5 other modes
    modeSel = 3'd2; expectOp(0, 3'd3, 2'd1); go(); waitIdle();
    modeSel = 3'd5; expectOp(0, 3'd4, 2'd1); go(); waitIdle();
    modeSel = 3'd4; expectOp(1, 3'd0, 2'd1); go(); waitIdle();
    drained("R5 verify/readcfg/flash");

    // R6 verify error during readback, then while idle
    modeSel = 3'd2; flashBank = 2'd0;
    expectOp(0, 3'd3, 2'd0); expectOp(0, 3'd0, 2'd0);
    go(); pulseVerify();
    waitIdle(); drained("R6 scrub after readback");
    modeSel = 3'd6;
    expectOp(0, 3'd0, 2'd0);
    pulseVerify(); waitIdle(); drained("R6 scrub from idle");

    // R10 error flags
    modeSel = 3'd0; injCfgErr = 1'b1;
    expectOp(0, 3'd0, 2'd0); go(); waitIdle();
    check(scrubErrFlag && !cfgErrFlag, "R10 scrub error flag", {scrubErrFlag, cfgErrFlag}, 2'b10);
    modeSel = 3'd3;
    expectOp(0, 3'd1, 2'd0); go(); waitIdle();
    drained("R4 clear error aborts configure");
    check(cfgErrFlag, "R10 cfg error flag", cfgErrFlag, 1);
    injCfgErr = 1'b0; injFlashErr = 1'b1; modeSel = 3'd4;
    expectOp(1, 3'd0, 2'd0); go(); waitIdle(); injFlashErr = 1'b0;
    check(flashErrFlag, "R10 flash error flag", flashErrFlag, 1);
    modeSel = 3'd0; expectOp(0, 3'd0, 2'd0); go(); waitIdle();
    check(scrubErrFlag && cfgErrFlag && flashErrFlag, "R10 flags sticky",
          {scrubErrFlag, cfgErrFlag, flashErrFlag}, 3'b111);
    @(negedge clk); statusClr = 1'b1; @(negedge clk); statusClr = 1'b0;
    check({scrubErrFlag, cfgErrFlag, flashErrFlag} == 3'b000, "R10 flags cleared",
          {scrubErrFlag, cfgErrFlag, flashErrFlag}, 0);

    // R11 bank latched at start
    flashBank = 2'd3; expectOp(0, 3'd0, 2'd3);
    go(); flashBank = 2'd0; @(negedge clk);
    check(imageBank == 2'd3 && busy, "R11 bank held", imageBank, 3);
    waitIdle(); drained("R11 bank");

    // R7 continuous: engine replies 4 cycles after start, gap = 4 + scrubRate + 1
    scrubRate = 24'd20;
    repeat (3) expectOp(0, 3'd0, 2'd0);
    modeSel = 3'd1;
    waitStart(t1); waitStart(t2); waitStart(t3);
    modeSel = 3'd6;
    check(t2 - t1 == 25, "R7 scrub period", 32'(t2 - t1), 32'd25);
    check(t3 - t2 == 25, "R7 scrub period", 32'(t3 - t2), 32'd25);
    waitIdle(); drained("R7 continuous");

    // R8 watchdog disabled by zero
    petOn = 1'b0; s = startCnt; waitCycles(200);
    check(startCnt == s, "R8 wdMax zero disables", 32'(startCnt), 32'(s));
    // R8 life pulses keep it quiet
    petOn = 1'b1; wdMax = 24'd40; s = startCnt; waitCycles(150);
    check(startCnt == s, "R8 pulses reload", 32'(startCnt), 32'(s));
    // R8 expiry -> clear+configure; R9 long operations do not re-trigger
    cfgLat = 60;
    expectOp(0, 3'd1, 2'd0); expectOp(0, 3'd2, 2'd0);
    petOn = 1'b0; tStop = cyc;
    waitStart(t1);
    check((t1 - tStop) >= 28 && (t1 - tStop) <= 46, "R8 expiry time", 32'(t1 - tStop), 32'd40);
    waitStart(t2);
    waitIdle();
    s = startCnt; waitCycles(26);
    check(startCnt == s, "R9 watchdog held during reload", 32'(startCnt), 32'(s));
    petOn = 1'b1; wdMax = '0; cfgLat = 3;
    waitCycles(60);
    check(startCnt == s, "R9 no late hard reset", 32'(startCnt), 32'(s));
    drained("R8 hard reset sequence");

    finishRun();
  end

endmodule